// File: doc/BRIEF.md
# Two-way cache hit and miss classifier

This block models only the tags of a 64-byte, two-way set-associative cache with least-recently-used replacement. It sees a stream of 12-bit byte addresses. An address may be presented in any cycle with a valid strobe. For each accepted address the block reports one outcome: a hit, a first-reference (compulsory) miss, or a conflict miss. A conflict miss is a miss on a block that was used before but has since been evicted.

The classification rests on a history bitmap. It has one bit per 16-byte memory block, 256 in all, and it records every block ever referenced since reset. This bitmap sits next to the tag array, which has two sets of two ways. Three saturating counters keep a running total of each outcome. The block holds no data, handles no writes and has no refill timing. Every lookup and every update completes in one clock.

Top module: `miss_class_cache`

## Requirements
- R1: An address splits into byte offset [3:0], set index [4] and a 7-bit tag [11:5]. The block number is [11:4], and a second access to a resident block hits whatever its offset.
- R2: The cache has 2 sets of 2 lines of 16 bytes. A miss into a set with an empty line fills line 0 before line 1, without evicting anything.
- R3: Replacement is least-recently-used per set. A hit or a fill makes that line most recent, and a miss into a full set replaces the least recent line.
- R4: A miss on a block number never referenced since reset is reported on `cold_miss`.
- R5: A miss on a block number referenced earlier but no longer resident is reported on `conf_miss`.
- R6: `hit`, `cold_miss` and `conf_miss` are registered and at most one of them is high. Exactly one of them is high in the cycle after each clock edge that accepts an address.
- R7: While `req_vld` is low, no cache, LRU or history state changes, and all three outcome outputs are low.
- R8: `hit_cnt`, `cold_cnt` and `conf_cnt` are 16-bit counters. Each one advances together with its outcome pulse and stops at 0xFFFF.
- R9: A synchronous active-high `rst` clears the valid bits, LRU state, history, counters and outputs.
- R10: The hex address sequence 100, 108, 114, 1C7, 128, 1B5, 100, 108, 1C7 gives cold, hit, cold, cold, cold, cold, conflict, hit, conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_vld | input | 1 | Address strobe |
| req_addr | input | 12 | Byte address |
| hit | output | 1 | Previous access hit |
| cold_miss | output | 1 | Previous access was a first-reference miss |
| conf_miss | output | 1 | Previous access missed on an evicted block |
| hit_cnt | output | 16 | Saturating hit count |
| cold_cnt | output | 16 | Saturating first-reference miss count |
| conf_cnt | output | 16 | Saturating conflict miss count |

## Verification
An address accepted at a rising edge has its outcome flag high, and its counter already advanced, from that edge until the next one. The bench drives on falling edges and samples outputs on the following falling edge, half a cycle after the flags and counters update. An idle strobe must show all flags low in that same window. Resident state touched during idle cycles is then exposed by the outcome of the next access.

// File: rtl/miss_class_cache.sv
module miss_class_cache #(
  parameter int ADDR_W = 12,
  parameter int OFF_W  = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_vld,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              hit,
  output logic              cold_miss,
  output logic              conf_miss,
  output logic [CNT_W-1:0]  hit_cnt,
  output logic [CNT_W-1:0]  cold_cnt,
  output logic [CNT_W-1:0]  conf_cnt
);
  localparam int BLK_W = ADDR_W - OFF_W;
  localparam int TAG_W = BLK_W - 1;
  localparam int NBLK  = 1 << BLK_W;

  logic [TAG_W-1:0] tag_q [2][2];
  logic             val_q [2][2];
  logic             lru_q [2];
  logic [NBLK-1:0]  seen_q;

  wire [BLK_W-1:0] blk = req_addr[ADDR_W-1:OFF_W];
  wire             set = req_addr[OFF_W];
  wire [TAG_W-1:0] tag = req_addr[ADDR_W-1:OFF_W+1];

  wire hit0 = val_q[set][0] && tag_q[set][0] == tag;
  wire hit1 = val_q[set][1] && tag_q[set][1] == tag;
  wire any_hit = hit0 | hit1;
  wire fill_way = !val_q[set][0] ? 1'b0 : !val_q[set][1] ? 1'b1 : lru_q[set];
  wire use_way = any_hit ? hit1 : fill_way;
  wire was_seen = seen_q[blk];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < 2; s++) begin
        lru_q[s] <= 1'b0;
        for (int w = 0; w < 2; w++) begin
          val_q[s][w] <= 1'b0;
          tag_q[s][w] <= '0;
        end
      end
      seen_q    <= '0;
      hit       <= 1'b0;
      cold_miss <= 1'b0;
      conf_miss <= 1'b0;
      hit_cnt   <= '0;
      cold_cnt  <= '0;
      conf_cnt  <= '0;
    end else begin
      hit       <= req_vld && any_hit;
      cold_miss <= req_vld && !any_hit && !was_seen;
      conf_miss <= req_vld && !any_hit && was_seen;
      if (req_vld) begin
        seen_q[blk]  <= 1'b1;
        lru_q[set]   <= ~use_way;
        if (!any_hit) begin
          val_q[set][use_way] <= 1'b1;
          tag_q[set][use_way] <= tag;
        end
        if (any_hit && hit_cnt != '1) hit_cnt <= hit_cnt + 1'b1;
        if (!any_hit && !was_seen && cold_cnt != '1) cold_cnt <= cold_cnt + 1'b1;
        if (!any_hit && was_seen && conf_cnt != '1) conf_cnt <= conf_cnt + 1'b1;
      end
    end
  end

  p_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit, cold_miss, conf_miss}));
  p_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    $past(req_vld) && !$past(rst) |-> $countones({hit, cold_miss, conf_miss}) == 1);
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(req_vld) |-> !hit && !cold_miss && !conf_miss);
  p_hit_step_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && hit && $past(hit_cnt) != '1 |-> hit_cnt == $past(hit_cnt) + 1'b1);
  p_hit_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !hit |-> $stable(hit_cnt));
  p_cold_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !cold_miss |-> $stable(cold_cnt));
  p_conf_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !conf_miss |-> $stable(conf_cnt));
  p_sat_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(conf_cnt) == '1 |-> conf_cnt == '1);
  p_reset_r9: assert property (@(posedge clk)
    $past(rst) |-> !hit && !cold_miss && !conf_miss && hit_cnt == '0 && cold_cnt == '0 && conf_cnt == '0);
endmodule

// File: tb/test_miss_class_cache.sv
module test_miss_class_cache;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_vld = 1'b0;
  logic [11:0] req_addr = '0;
  logic hit, cold_miss, conf_miss;
  logic [15:0] hit_cnt, cold_cnt, conf_cnt;

  always #4 clk = ~clk;

  miss_class_cache i_miss_class_cache (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_addr(req_addr),
    .hit(hit), .cold_miss(cold_miss), .conf_miss(conf_miss),
    .hit_cnt(hit_cnt), .cold_cnt(cold_cnt), .conf_cnt(conf_cnt)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [6:0] m_tag [2][2];
  logic       m_val [2][2];
  logic       m_lru [2];
  logic       m_seen [256];
  int         m_cnt [3];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < 2; s++) begin
      m_lru[s] = 0;
      for (int w = 0; w < 2; w++) begin m_val[s][w] = 0; m_tag[s][w] = 0; end
    end
    for (int b = 0; b < 256; b++) m_seen[b] = 0;
    for (int k = 0; k < 3; k++) m_cnt[k] = 0;
  endtask

  // returns 0 hit, 1 first-reference miss, 2 conflict miss
  function automatic int model_step(input logic [11:0] a);
    int s, w, res;
    logic [6:0] t;
    s = a / 16 % 2;
    t = 7'(a / 32);
    res = -1;
    w = 0;
    for (int k = 0; k < 2; k++)
      if (m_val[s][k] && m_tag[s][k] == t) begin res = 0; w = k; end
    if (res != 0) begin
      res = m_seen[a / 16] ? 2 : 1;
      w = !m_val[s][0] ? 0 : !m_val[s][1] ? 1 : int'(m_lru[s]);
      m_val[s][w] = 1;
      m_tag[s][w] = t;
    end
    m_lru[s] = (w == 0);
    m_seen[a / 16] = 1;
    if (m_cnt[res] < 65535) m_cnt[res]++;
    return res;
  endfunction

  task automatic access(input logic [11:0] a, input string req, input bit full);
    int e;
    e = model_step(a);
    @(negedge clk);
    req_vld = 1'b1;
    req_addr = a;
    @(negedge clk);
    req_vld = 1'b0;
    if (full || {hit, cold_miss, conf_miss} != {e == 0, e == 1, e == 2})
      chk({hit, cold_miss, conf_miss} == {e == 0, e == 1, e == 2}, req,
          int'({hit, cold_miss, conf_miss}), int'({e == 0, e == 1, e == 2}));
    if (full || hit_cnt != m_cnt[0] || cold_cnt != m_cnt[1] || conf_cnt != m_cnt[2])
      chk(hit_cnt == m_cnt[0] && cold_cnt == m_cnt[1] && conf_cnt == m_cnt[2], "R8 counts",
          int'({hit_cnt, cold_cnt}), m_cnt[0] * 65536 + m_cnt[1]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req_vld = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  initial begin
    #(8 * 195000);
    done = 1;
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [11:0] seq [9];
    int expv [9];
    logic [11:0] lf;
    logic [15:0] h0, c0, f0;
    seq = '{12'h100, 12'h108, 12'h114, 12'h1C7, 12'h128, 12'h1B5, 12'h100, 12'h108, 12'h1C7};
    expv = '{1, 0, 1, 1, 1, 1, 2, 0, 2};
    do_reset();
    // R9 reset state
    chk(!hit && !cold_miss && !conf_miss, "R9 flags", int'({hit, cold_miss, conf_miss}), 0);
    chk(hit_cnt == 0 && cold_cnt == 0 && conf_cnt == 0, "R9 counters", int'(hit_cnt + cold_cnt + conf_cnt), 0);

    // R10 fixed sequence, with R1 offset hit, R2 fill order, R3 LRU, R4, R5
    for (int i = 0; i < 9; i++) begin
      int e;
      e = model_step(seq[i]);
      chk(e == expv[i], "R10 model", e, expv[i]);
      @(negedge clk);
      req_vld = 1'b1;
      req_addr = seq[i];
      @(negedge clk);
      req_vld = 1'b0;
      chk({hit, cold_miss, conf_miss} == {expv[i] == 0, expv[i] == 1, expv[i] == 2},
          "R10 R3 R4 R5 outcome", int'({hit, cold_miss, conf_miss}), expv[i]);
    end
    chk(hit_cnt == 2 && cold_cnt == 5 && conf_cnt == 2, "R10 R8 totals",
        int'({hit_cnt[3:0], cold_cnt[3:0], conf_cnt[3:0]}), 12'h252);

    // R7 idle strobe: flags low, counters held, then state exposed by an access
    h0 = hit_cnt; c0 = cold_cnt; f0 = conf_cnt;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      req_addr = 12'(i * 16 + 12'h300);
      chk(!hit && !cold_miss && !conf_miss, "R7 idle flags", int'({hit, cold_miss, conf_miss}), 0);
      chk(hit_cnt == h0 && cold_cnt == c0 && conf_cnt == f0, "R7 idle counters", int'(hit_cnt), int'(h0));
    end
    access(12'h10C, "R7 R1 resident after idle", 1);
    access(12'h1CF, "R7 R1 resident after idle", 1);
    access(12'h30F, "R7 R4 idle address not recorded", 1);

    // R1 R2 R3 R4 R5 sweep of every block number, twice
    do_reset();
    for (int r = 0; r < 2; r++)
      for (int b = 0; b < 256; b++)
        access(12'(b * 16 + (b + r) % 16), "R4 R5 block sweep", b % 64 == 0);

    // R3 R5 pseudo-random stream on a few blocks
    lf = 12'hACE;
    for (int i = 0; i < 1500; i++) begin
      lf = {lf[10:0], lf[11] ^ lf[10] ^ lf[9] ^ lf[3]};
      access(lf & 12'h07F | (i % 3 == 0 ? 12'h080 : 12'h000), "R3 R5 random", i % 100 == 0);
    end

    // R9 reset clears history: known block is a first-reference miss again
    do_reset();
    chk(hit_cnt == 0 && cold_cnt == 0 && conf_cnt == 0, "R9 counters cleared", int'(hit_cnt), 0);
    access(12'h100, "R9 R4 history cleared", 1);
    access(12'h104, "R1 same block hit", 1);
    access(12'h110, "R2 other set first fill", 1);

    // R8 saturation of the hit counter
    for (int i = 0; i < 66000; i++) access(12'h100, "R8 saturation", i > 65530);
    chk(hit_cnt == 16'hFFFF, "R8 saturated", int'(hit_cnt), 16'hFFFF);

    if (!done) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule